// File: doc/BRIEF.md
# Variable-length integer byte decoder

The decoder takes a stream of bytes on a valid/ready input and rebuilds 32-bit unsigned integers from it. Each byte holds a seven-bit payload group in bits [6:0] and a continuation flag in bit 7. The groups are combined least significant first. The first byte of an integer supplies bits [6:0] of the value, the second supplies bits [13:7], and so on. A byte with its flag clear ends the integer, and the finished value is offered on a valid/ready output.

An encoding that runs past five bytes is flagged as an error, and so is a fifth byte whose payload does not fit in 32 bits. When either happens, `err_o` pulses and no value is produced. If the faulty fifth byte still asked for more bytes, the decoder drops input until a terminating byte arrives, then starts a new integer. Only one finished value can wait at the output. While it waits, the decoder takes no new bytes.

Top module: `varint_dec`

## Requirements
- R1: After reset, `out_valid_o` and `err_o` are low and `in_ready_o` is high.
- R2: A lone byte with bit 7 clear decodes to its bits [6:0]. For example, 0x11 gives 17.
- R3: Payload groups combine least significant first, with group k placed at bit 7k. The sequence 0xC1, 0x0D gives 1729. The sequence 0xFF, 0xFF, 0x7F gives 0x1FFFFF. The sequence 0x80, 0x80, 0x04 gives 65536.
- R4: `out_valid_o` rises in the cycle after the terminating byte is accepted. While `out_ready_i` is low, it stays high and `out_data_o` stays unchanged.
- R5: `in_ready_o` is low whenever a result is pending (`out_valid_o` high).
- R6: A five-byte encoding whose fifth byte is at most 0x0F decodes without error. For example, 0xFF, 0xFF, 0xFF, 0xFF, 0x0F gives 0xFFFFFFFF.
- R7: A fifth byte with bit 7 set raises `err_o` and produces no output. The decoder then discards bytes up to and including the next byte with bit 7 clear. The integer after that decodes normally.
- R8: A fifth byte with bit 7 clear but any of bits [6:4] set raises `err_o` and produces no output. The next byte starts a new integer.
- R9: The group position returns to zero after every completed or rejected integer, so integers sent back to back decode independently.
- R10: `err_o` is a pulse lasting one cycle, in the cycle after the offending byte is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte is valid |
| in_data_i | input | 8 | Input byte: bit 7 is the continuation flag, bits [6:0] are payload |
| in_ready_o | output | 1 | Decoder accepts a byte |
| out_valid_o | output | 1 | Decoded integer available |
| out_data_o | output | 32 | Decoded integer |
| out_ready_i | input | 1 | Downstream takes the integer |
| err_o | output | 1 | Overlong or overflowing encoding detected |

## Verification
The fifth byte of an encoding can be both the end of an integer and an error. When it is, overflow detection and resynchronisation fall on the same byte. The decoder must flag the error, release no value and reset its group position, all from that one byte. The bench provokes this with 0x80 four times followed by 0x10, then sends 0x03. It judges the result by one `err_o` pulse, no output handshake for the bad sequence, and a clean value of 3 for the next byte. A second collision comes from a stalled output meeting a pending input byte: holding `out_ready_i` low must keep `in_ready_o` low and the held value stable. A cycle-accurate model checks both collisions on every clock under random traffic as well.

// File: rtl/varint_pkg.sv
package varint_pkg;
  typedef enum logic {
    MODE_COLLECT = 1'b0,
    MODE_SKIP    = 1'b1
  } vdec_mode_e;
endpackage

// File: rtl/varint_acc.sv
module varint_acc
  import varint_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int GRP_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [GRP_W:0]    byte_i,
  output logic              done_o,
  output logic              bad_o,
  output logic [DATA_W-1:0] value_o
);
  localparam int MAX_GRP = (DATA_W + GRP_W - 1) / GRP_W;
  localparam int IDX_W   = $clog2(MAX_GRP + 1);
  localparam int SH_W    = $clog2(DATA_W);
  localparam int SPILL   = DATA_W - GRP_W * (MAX_GRP - 1);

  vdec_mode_e          mode_q;
  logic [IDX_W-1:0]    idx_q;
  logic [DATA_W-1:0]   acc_q;
  logic [GRP_W-1:0]    pay;
  logic                cont, last, spill, collect;
  logic [SH_W-1:0]     shamt;

  assign pay     = byte_i[GRP_W-1:0];
  assign cont    = byte_i[GRP_W];
  assign last    = (idx_q == IDX_W'(MAX_GRP - 1));
  assign collect = take_i && (mode_q == MODE_COLLECT);
  assign shamt   = SH_W'(idx_q) * SH_W'(GRP_W);

  // payload bits that land above the top of the result on the final group
  generate
    if (SPILL < GRP_W) begin : g_spill
      assign spill = |pay[GRP_W-1:SPILL];
    end else begin : g_nospill
      assign spill = 1'b0;
    end
  endgenerate

  assign bad_o   = collect && last && (cont || spill);
  assign done_o  = collect && !cont && !bad_o;
  assign value_o = acc_q | (DATA_W'(pay) << shamt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_COLLECT;
      idx_q  <= '0;
      acc_q  <= '0;
    end else if (take_i) begin
      if (mode_q == MODE_SKIP) begin
        if (!cont) mode_q <= MODE_COLLECT;
      end else if (bad_o) begin
        idx_q  <= '0;
        acc_q  <= '0;
        mode_q <= cont ? MODE_SKIP : MODE_COLLECT;
      end else if (!cont) begin
        idx_q <= '0;
        acc_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
        acc_q <= value_o;
      end
    end
  end
endmodule

// File: rtl/varint_hold.sv
module varint_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/varint_dec.sv
module varint_dec #(
  parameter int DATA_W = 32,
  parameter int GRP_W  = 7,
  localparam int BYTE_W = GRP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic              err_o
);
  logic              take, done, bad;
  logic [DATA_W-1:0] value;

  // single result slot: stall input until it drains
  assign in_ready_o = !out_valid_o;
  assign take       = in_valid_i && in_ready_o;

  varint_acc #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .byte_i (in_data_i),
    .done_o (done),
    .bad_o  (bad),
    .value_o(value)
  );

  varint_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (done),
    .data_i (value),
    .ready_i(out_ready_i),
    .valid_o(out_valid_o),
    .data_o (out_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= bad;
  end
endmodule

// File: rtl/varint_dec_chk.sv
module varint_dec_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_ready_i,
  input logic              err_o
);
  AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o); // R5

  AST_HOLD_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R4

  AST_VALID_AFTER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o)); // R4

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R10

  AST_ERR_NO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !out_valid_o); // R7
endmodule

bind varint_dec varint_dec_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_varint_dec.sv
module tb_varint_dec;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        out_ready = 1'b1;
  logic        in_ready_o, out_valid_o, err_o;
  logic [31:0] out_data_o;

  int n_chk = 0, n_fail = 0, err_cnt = 0;
  bit rand_rdy = 1'b0;
  logic [31:0] got[$];

  always #2 clk = ~clk;

  varint_dec dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_ready_i(out_ready), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int          m_idx;
  longint      m_acc;
  bit          m_skip, m_ov, m_err;
  logic [31:0] m_data;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_idx = 0; m_acc = 0; m_skip = 0; m_ov = 0; m_err = 0; m_data = 0;
    end else begin
      bit     take;
      longint tot;
      take  = in_valid && !m_ov;
      m_err = 0;
      if (m_ov && out_ready) m_ov = 0;
      if (take) begin
        if (m_skip) begin
          if (!in_data[7]) m_skip = 0;
        end else begin
          tot = m_acc + (longint'(in_data[6:0]) << (7 * m_idx));
          if (m_idx == 4 && (in_data[7] || (tot >> 32) != 0)) begin
            m_err = 1; m_skip = in_data[7]; m_idx = 0; m_acc = 0;
          end else if (!in_data[7]) begin
            m_ov = 1; m_data = tot[31:0]; m_idx = 0; m_acc = 0;
          end else begin
            m_acc = tot; m_idx++;
          end
        end
      end
      #1;
      chk(out_valid_o == m_ov, "R4 out_valid_o vs model", longint'(out_valid_o), longint'(m_ov));
      chk(in_ready_o == !m_ov, "R5 in_ready_o vs model", longint'(in_ready_o), longint'(!m_ov));
      chk(err_o == m_err, "R10 err_o vs model", longint'(err_o), longint'(m_err));
      if (m_ov)
        chk(out_data_o == m_data, "R3 out_data_o vs model", longint'(out_data_o), longint'(m_data));
    end
  end

  always @(posedge clk) begin
    if (rst_ni && out_valid_o && out_ready) got.push_back(out_data_o);
    if (rst_ni && err_o) err_cnt++;
  end

  always @(negedge clk) if (rand_rdy) out_ready = 1'($urandom_range(0, 1));

  task automatic send(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_data = b;
    while (!in_ready_o) @(negedge clk);
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic expect_one(input logic [31:0] exp, input string tag);
    repeat (3) @(negedge clk);
    chk(got.size() == 1, {tag, " result count"}, longint'(got.size()), 1);
    if (got.size() > 0) begin
      logic [31:0] v;
      v = got.pop_front();
      chk(v == exp, tag, longint'(v), longint'(exp));
    end
    got.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int e0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!out_valid_o && !err_o && in_ready_o, "R1 reset state",
        longint'({out_valid_o, err_o, in_ready_o}), 64'h1);

    send(8'h11);                          expect_one(32'd17, "R2 single byte 0x11");
    send(8'hC1); send(8'h0D);             expect_one(32'd1729, "R3 two bytes 1729");
    send(8'hFF); send(8'hFF); send(8'h7F); expect_one(32'h1FFFFF, "R3 three bytes max");
    send(8'h80); send(8'h80); send(8'h04); expect_one(32'd65536, "R3 three bytes 2^16");
    send(8'hFF); send(8'hFF); send(8'hFF); send(8'hFF); send(8'h0F);
    expect_one(32'hFFFFFFFF, "R6 five byte max");
    send(8'h05);                          expect_one(32'd5, "R9 shift reset after integer");

    e0 = err_cnt;
    send(8'h80); send(8'h80); send(8'h80); send(8'h80); send(8'h81);
    send(8'h85); send(8'h7F);
    repeat (3) @(negedge clk);
    chk(got.size() == 0, "R7 no output for overlong", longint'(got.size()), 0);
    chk(err_cnt == e0 + 1, "R7 one error pulse", longint'(err_cnt - e0), 1);
    send(8'h22);                          expect_one(32'd34, "R7 resync after overlong");

    e0 = err_cnt;
    send(8'h80); send(8'h80); send(8'h80); send(8'h80); send(8'h10);
    repeat (3) @(negedge clk);
    chk(got.size() == 0, "R8 no output for overflow", longint'(got.size()), 0);
    chk(err_cnt == e0 + 1, "R8 one error pulse", longint'(err_cnt - e0), 1);
    send(8'h03);                          expect_one(32'd3, "R8 next byte starts fresh");

    out_ready = 1'b0;
    send(8'h11);
    @(negedge clk); in_valid = 1'b1; in_data = 8'h05;
    repeat (3) @(negedge clk);
    chk(out_valid_o && out_data_o == 32'd17, "R4 held while stalled",
        longint'(out_data_o), 17);
    chk(!in_ready_o, "R5 input blocked while pending", longint'(in_ready_o), 0);
    out_ready = 1'b1;
    @(negedge clk); @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(got.size() == 2, "R4 stall released both results", longint'(got.size()), 2);
    got.delete();

    rand_rdy = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      in_valid = ($urandom_range(0, 3) != 0);
      in_data  = {1'($urandom_range(0, 2) != 0), 7'($urandom)};
    end
    @(negedge clk); in_valid = 1'b0; rand_rdy = 1'b0; out_ready = 1'b1;
    repeat (5) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule